// File: doc/BRIEF.md
# Power-Fail Memory Write-Protect Gate

This block sits between a memory controller and a battery-backed SRAM and gates the active-low chip-enable and write-enable strobes using a synchronous power-fail flag. While the supply is healthy, each strobe output copies its input. When the flag rises, a strobe that is mid-cycle (input low) may stay low so the access can finish. It is then cut off when its input returns high, or after a bounded number of clock cycles, whichever comes first. A strobe that was idle at that moment is blocked at once. Both strobes then stay high until the flag clears. An active-low power-fail output reports the condition.

An enable input selects between full mode and a legacy mode. In legacy mode the write-enable input is ignored, and the write-enable and power-fail outputs are released. Those two outputs are modelled as value plus output-enable pairs. All pins are plain control signals; there is no data stream and no handshake.

Top module: `pfg_gate`

## Requirements
- R1: Strobes are active low. While `pf_n_o` is high, `ce_n_o` equals `ce_n_i` in the same cycle. While `pf_n_o` is high and `en_i` is 1, `we_n_o` equals `we_n_i`.
- R2: `pf_n_o` goes low at the first rising clock edge that samples `pwr_fail_i` high. It returns high at the first edge that samples it low. It resets high.
- R3: If `ce_n_i` is low at the edge that first samples `pwr_fail_i` high, `ce_n_o` stays low while `ce_n_i` stays low. It goes high in the same cycle that `ce_n_i` goes high.
- R4: In a held chip-enable cycle, `ce_n_o` is low in at most `TIMEOUT_CYC` consecutive cycles while `pf_n_o` is low. After that it is forced high whatever `ce_n_i` does.
- R5: Write-enable follows the rules of R3 and R4 on its own, with its own counter. A chip-enable release or timeout does not change it.
- R6: A strobe whose input is high at the power-fail edge is blocked at once. Once a strobe is blocked, a new falling edge on its input during power fail does not drive its output low.
- R7: A blocked strobe output stays high while `pwr_fail_i` stays high. Strobes follow their inputs again from the edge that samples `pwr_fail_i` low.
- R8: With `en_i` = 0 (legacy), `we_oe_o` and `pf_oe_o` are 0 and `we_n_o` is 1 whatever `we_n_i` does. The chip-enable path still obeys R1 and R3 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail_i | input | 1 | Synchronous power-fail flag, 1 = supply out of tolerance |
| en_i | input | 1 | 1 = full mode, 0 = legacy mode |
| ce_n_i | input | 1 | Chip-enable from controller, active low |
| we_n_i | input | 1 | Write-enable from controller, active low |
| ce_n_o | output | 1 | Gated chip-enable to memory, active low |
| we_n_o | output | 1 | Gated write-enable to memory, active low |
| we_oe_o | output | 1 | Output enable for `we_n_o` |
| pf_n_o | output | 1 | Power-fail indication, active low |
| pf_oe_o | output | 1 | Output enable for `pf_n_o` |

## Verification
The bench drops power while the chip-enable is mid-access and the write-enable is idle, and the reverse. A design that shares one hold state or one counter between the strobes would release or time out the wrong one. It re-lowers a blocked input during power fail to catch a gate that reopens on a new cycle. It runs a held strobe to exactly the timeout, which exposes a counter that is one cycle off in either direction. It also checks the recovery cycle and legacy mode, where a design that drops the write path too late, or still honours `we_n_i`, shows a wrong output or enable.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    GATE_OPEN  = 2'd0,
    GATE_HOLD  = 2'd1,
    GATE_BLOCK = 2'd2
  } gate_st_t;

  localparam int unsigned NUM_STROBES = 2;
  localparam int unsigned IDX_CE = 0;
  localparam int unsigned IDX_WE = 1;
endpackage

// File: rtl/pfg_detect.sv
module pfg_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  output logic fail_q_o,
  output logic fail_edge_o
);
  logic fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= pwr_fail_i;
  end

  assign fail_q_o    = fail_q;
  assign fail_edge_o = pwr_fail_i & ~fail_q;
endmodule

// File: rtl/pfg_strobe.sv
module pfg_strobe
  import pfg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_lvl_i,
  input  logic fail_edge_i,
  input  logic strb_n_i,
  output logic strb_n_o
);
  localparam int unsigned CNT_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  gate_st_t         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!fail_lvl_i) begin
      st_d  = GATE_OPEN;
      cnt_d = '0;
    end else if (fail_edge_i) begin
      st_d  = strb_n_i ? GATE_BLOCK : GATE_HOLD;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        GATE_HOLD: begin
          if (strb_n_i || cnt_q == LAST) st_d = GATE_BLOCK;
          else                           cnt_d = cnt_q + 1'b1;
        end
        GATE_BLOCK: st_d = GATE_BLOCK;
        default:    st_d = GATE_BLOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GATE_OPEN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // A held strobe passes its input, so a rising input ends it this cycle.
  assign strb_n_o = strb_n_i | (st_q == GATE_BLOCK);
endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
  import pfg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic en_i,
  input  logic ce_n_i,
  input  logic we_n_i,
  output logic ce_n_o,
  output logic we_n_o,
  output logic we_oe_o,
  output logic pf_n_o,
  output logic pf_oe_o
);
  logic fail_q, fail_edge;
  logic [NUM_STROBES-1:0] strb_in, strb_out;

  pfg_detect u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_fail_i  (pwr_fail_i),
    .fail_q_o    (fail_q),
    .fail_edge_o (fail_edge)
  );

  assign strb_in[IDX_CE] = ce_n_i;
  assign strb_in[IDX_WE] = we_n_i | ~en_i;

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strb
    pfg_strobe #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_strb (
      .clk         (clk),
      .rst_n       (rst_n),
      .fail_lvl_i  (pwr_fail_i),
      .fail_edge_i (fail_edge),
      .strb_n_i    (strb_in[g]),
      .strb_n_o    (strb_out[g])
    );
  end

  assign ce_n_o  = strb_out[IDX_CE];
  assign we_n_o  = strb_out[IDX_WE];
  assign we_oe_o = en_i;
  assign pf_n_o  = ~fail_q;
  assign pf_oe_o = en_i;
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int unsigned TIMEOUT_CYC = 300
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail_i,
  input logic en_i,
  input logic ce_n_i,
  input logic we_n_i,
  input logic ce_n_o,
  input logic we_n_o,
  input logic we_oe_o,
  input logic pf_n_o,
  input logic pf_oe_o
);
  localparam int unsigned RW = $clog2(TIMEOUT_CYC + 2);

  logic [RW-1:0] ce_run, we_run;
  logic ce_low_f, we_low_f;

  assign ce_low_f = !pf_n_o && !ce_n_o;
  assign we_low_f = !pf_n_o && !we_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_run <= '0;
      we_run <= '0;
    end else begin
      ce_run <= ce_low_f ? ((ce_run == '1) ? ce_run : ce_run + 1'b1) : '0;
      we_run <= we_low_f ? ((we_run == '1) ? we_run : we_run + 1'b1) : '0;
    end
  end

  assert_ce_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pf_n_o |-> (ce_n_o == ce_n_i));
  assert_we_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_n_o && en_i) |-> (we_n_o == we_n_i));
  assert_pf_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> !pf_n_o);
  assert_pf_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_fail_i |=> pf_n_o);
  assert_ce_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_low_f |-> (ce_run < RW'(TIMEOUT_CYC)));
  assert_we_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_low_f |-> (we_run < RW'(TIMEOUT_CYC)));
  assert_ce_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_n_o && pwr_fail_i && ce_n_o) |=> ce_n_o);
  assert_we_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_n_o && pwr_fail_i && we_n_o) |=> we_n_o);
  assert_legacy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (!we_oe_o && !pf_oe_o && we_n_o));
endmodule

bind pfg_gate pfg_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_fail_i (pwr_fail_i),
  .en_i       (en_i),
  .ce_n_i     (ce_n_i),
  .we_n_i     (we_n_i),
  .ce_n_o     (ce_n_o),
  .we_n_o     (we_n_o),
  .we_oe_o    (we_oe_o),
  .pf_n_o     (pf_n_o),
  .pf_oe_o    (pf_oe_o)
);

// File: tb/pfg_gate_tb.sv
`timescale 1ns/1ps
module pfg_gate_tb;
  localparam int unsigned T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail_i = 1'b0, en_i = 1'b1, ce_n_i = 1'b1, we_n_i = 1'b1;
  logic ce_n_o, we_n_o, we_oe_o, pf_n_o, pf_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic ce, we, pf, weoe, pfoe;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  pfg_gate #(.TIMEOUT_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail_i), .en_i(en_i),
    .ce_n_i(ce_n_i), .we_n_i(we_n_i), .ce_n_o(ce_n_o), .we_n_o(we_n_o),
    .we_oe_o(we_oe_o), .pf_n_o(pf_n_o), .pf_oe_o(pf_oe_o)
  );

  task automatic cmp(input string tag, input string sig, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, sig, act, exp, $time);
    end
  endtask

  // Driver: applies inputs after a falling edge and queues what should appear.
  task automatic step(input logic ci, wi, pfi, eni,
                      input logic ece, ewe, epf, ewoe, epoe, input string tag);
    exp_t e;
    @(negedge clk);
    ce_n_i = ci; we_n_i = wi; pwr_fail_i = pfi; en_i = eni;
    e.ce = ece; e.we = ewe; e.pf = epf; e.weoe = ewoe; e.pfoe = epoe; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: samples just before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.tag, "ce_n_o",  ce_n_o,  e.ce);
        cmp(e.tag, "we_n_o",  we_n_o,  e.we);
        cmp(e.tag, "pf_n_o",  pf_n_o,  e.pf);
        cmp(e.tag, "we_oe_o", we_oe_o, e.weoe);
        cmp(e.tag, "pf_oe_o", pf_oe_o, e.pfoe);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // Reset state (R2 reset high, R1 follow)
    step(0,1,0,1, 0,1,1,1,1, "R1 reset");
    step(1,0,1,1, 1,0,1,1,1, "R2 reset pf held high");
    @(negedge clk); rst_n = 1'b1;
    ce_n_i = 1; we_n_i = 1; pwr_fail_i = 0;

    // R1 nominal patterns
    step(0,0,0,1, 0,0,1,1,1, "R1 both low");
    step(1,0,0,1, 1,0,1,1,1, "R1 we only");
    step(0,1,0,1, 0,1,1,1,1, "R1 ce only");
    step(1,1,0,1, 1,1,1,1,1, "R1 idle");

    // CE mid-cycle, WE idle at fail
    step(0,1,1,1, 0,1,1,1,1, "R2 detect cycle");
    step(0,1,1,1, 0,1,0,1,1, "R3 ce held");
    step(0,0,1,1, 0,1,0,1,1, "R6 we new fall blocked");
    step(1,0,1,1, 1,1,0,1,1, "R3 ce released");
    step(0,0,1,1, 1,1,0,1,1, "R6 ce new fall blocked");
    step(0,0,0,1, 1,1,0,1,1, "R7 last blocked cycle");
    step(0,0,0,1, 0,0,1,1,1, "R7 recovered");

    // WE mid-cycle to timeout, CE idle at fail
    step(1,0,1,1, 1,0,1,1,1, "R5 detect cycle");
    for (int i = 0; i < T; i++)
      step(0,0,1,1, 1,0,0,1,1, "R5 we held, R6 ce blocked");
    step(0,0,1,1, 1,1,0,1,1, "R5 we timeout");
    step(0,0,1,1, 1,1,0,1,1, "R7 we stays blocked");
    step(0,0,0,1, 1,1,0,1,1, "R7 last blocked cycle");
    step(0,0,0,1, 0,0,1,1,1, "R7 recovered");

    // CE to timeout, WE idle
    step(0,1,1,1, 0,1,1,1,1, "R4 detect cycle");
    for (int i = 0; i < T; i++)
      step(0,1,1,1, 0,1,0,1,1, "R4 ce held");
    step(0,1,1,1, 1,1,0,1,1, "R4 ce timeout");
    step(0,1,0,1, 1,1,0,1,1, "R7 last blocked cycle");
    step(0,1,0,1, 0,1,1,1,1, "R7 recovered");

    // Legacy mode
    step(0,0,0,0, 0,1,1,0,0, "R8 we ignored");
    step(1,0,0,0, 1,1,1,0,0, "R8 we ignored ce high");
    step(1,1,0,0, 1,1,1,0,0, "R8 idle");
    step(0,1,1,0, 0,1,1,0,0, "R8 detect cycle");
    step(0,0,1,0, 0,1,0,0,0, "R8 ce held in legacy");
    step(1,0,1,0, 1,1,0,0,0, "R8 ce released in legacy");
    step(1,0,0,0, 1,1,0,0,0, "R8 last blocked cycle");
    step(0,0,0,0, 0,1,1,0,0, "R8 recovered");
    step(0,0,0,1, 0,0,1,1,1, "R1 re-enabled");

    @(negedge clk); @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule